// File: doc/BRIEF.md
# Expansion Memory Row-Select Decoder

This block lives on a DRAM expansion card and chooses which of up to eight memory rows gets the host's row strobe. The host memory controller supplies a two-bit row select and active-low row and column strobes. The host also puts a bank byte on the data bus early in every CPU cycle, marked by a cycle-start strobe. Configuration straps set how many rows are fitted (1, 2, 4 or 8) and the row size. The block reports the row size back to the host as a static level.

With four or fewer rows, the row index is the host's two-bit select alone, and the bank byte is never consulted. This keeps DMA cycles safe, because the data bus carries no valid bank byte during DMA. With eight rows, the block captures one bank bit when a cycle starts and prepends it to the row select. During DMA it keeps the previously captured bit and raises a diagnostic flag. A CAS-before-RAS refresh strobes every fitted row at once. All outputs are registered, so they change one clock after the inputs they follow.

Top module: `xram_row_decoder`

## Requirements
- R1: `row_size_big` equals the `cfg_big_rows` strap one clock later. A 0 means 256 KB rows with 9 multiplexed address pins (18 address bits). A 1 means 1 MB rows with 10 pins (20 address bits).
- R2: With `cfg_rows` set to 0, 1 or 2 (1, 2 or 4 rows), a normal access drives low only `row_ras_n[host_row_sel]`, one clock after the cycle in which `host_ras_n` is low. This applies when `host_row_sel` is below the row count.
- R3: The bank bit is `host_data[0]`. It is captured in the cycle in which `cyc_start` is first seen high after being low, provided `dma_cyc` is low. The captured value is held until the next such capture, and it is already used in the capture cycle.
- R4: With `cfg_rows`=3 (8 rows), the row index is {bank bit, `host_row_sel`}. The bank bit is the most significant bit.
- R5: With `cfg_rows` below 3, neither the bank bit nor `host_data` changes which row is strobed.
- R6: A normal access whose row index is at or above the configured row count drives no `row_ras_n` low. It sets `unpop_access` high one clock later.
- R7: In 8-row mode, an access with `dma_cyc` high uses the previously held bank bit and sets `dma_suspect` one clock later. In other modes `dma_suspect` stays low.
- R8: A refresh drives low every `row_ras_n` below the row count, and only those, regardless of the row index, with `unpop_access` low. A refresh is `host_ras_n` falling while `host_cas_n` is already low, with `host_cas_n` having been low and `host_ras_n` high in the previous clock.
- R9: During a normal access at most one `row_ras_n` is low. `card_cas_n` equals `host_cas_n` one clock later.
- R10: After synchronous reset, all `row_ras_n` and `card_cas_n` are high, `unpop_access`, `dma_suspect` and `row_size_big` are low, and the held bank bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_row_sel | input | 2 | Row select from host controller |
| host_ras_n | input | 1 | Host row strobe, active low |
| host_cas_n | input | 1 | Host column strobe, active low |
| host_data | input | 8 | Host data bus carrying the bank byte |
| cyc_start | input | 1 | CPU cycle-start strobe |
| dma_cyc | input | 1 | High during DMA cycles |
| cfg_rows | input | 2 | Row-count strap: 0=1, 1=2, 2=4, 3=8 rows |
| cfg_big_rows | input | 1 | Row-size strap: 0=256 KB, 1=1 MB |
| row_ras_n | output | 8 | Per-row RAS, active low, registered |
| card_cas_n | output | 1 | Buffered CAS, registered |
| row_size_big | output | 1 | Row-size indication to host |
| unpop_access | output | 1 | Access hit an unfitted row |
| dma_suspect | output | 1 | 8-row access during DMA, selection may be wrong |

## Verification
Several properties are checked on every clock. At most one row strobe is low outside refresh, and an unpopulated flag never coincides with a row strobe. The CAS and row-size outputs follow their inputs one clock later. The DMA flag appears only after an 8-row DMA access, and a refresh always reaches row 0. A selected fitted row being strobed in the smaller modes is also checked every clock. Bank-bit capture, its persistence across DMA, and the fact that the bank byte is ignored in the smaller modes all depend on history across several cycles. These are shown by the bench's directed access sequences, which a behavioural model compares on every clock.

// File: rtl/xrd_pkg.sv
package xrd_pkg;
  localparam int unsigned MAX_ROWS = 8;

  typedef enum logic [1:0] {
    ROWS_ONE   = 2'd0,
    ROWS_TWO   = 2'd1,
    ROWS_FOUR  = 2'd2,
    ROWS_EIGHT = 2'd3
  } row_cfg_e;

  function automatic logic [3:0] fitted_rows(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/xrd_bank_latch.sv
module xrd_bank_latch #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              dma_cyc,
  input  logic [DATA_W-1:0] data,
  output logic              bank_eff
);
  logic start_d;
  logic bank_q;
  logic take;

  assign take     = cyc_start && !start_d && !dma_cyc;
  assign bank_eff = take ? data[BANK_BIT] : bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_d <= 1'b0;
      bank_q  <= 1'b0;
    end else begin
      start_d <= cyc_start;
      if (take) bank_q <= data[BANK_BIT];
    end
  end
endmodule

// File: rtl/xrd_cbr_detect.sv
module xrd_cbr_detect (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  input  logic cas_n,
  output logic refresh
);
  logic armed;

  assign refresh = armed && !ras_n;

  always_ff @(posedge clk) begin
    if (rst)        armed <= 1'b0;
    else if (cas_n) armed <= 1'b0;
    else if (ras_n) armed <= 1'b1;
  end
endmodule

// File: rtl/xrd_row_drive.sv
module xrd_row_drive #(
  parameter int unsigned NUM_ROWS = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               refresh,
  input  logic               dma_flag,
  input  logic [IDX_W-1:0]   idx,
  input  logic [IDX_W:0]     count,
  output logic [NUM_ROWS-1:0] ras_n_q,
  output logic               cas_n_q,
  output logic               unpop_q,
  output logic               suspect_q
);
  logic [IDX_W:0] idx_x;
  logic           normal;
  logic           in_range;

  assign idx_x    = {1'b0, idx};
  assign normal   = !ras_n && !refresh;
  assign in_range = idx_x < count;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    localparam logic [IDX_W:0] ROW_ID = g[IDX_W:0];
    always_ff @(posedge clk) begin
      if (rst)          ras_n_q[g] <= 1'b1;
      else if (ras_n)   ras_n_q[g] <= 1'b1;
      else if (refresh) ras_n_q[g] <= !(ROW_ID < count);
      else              ras_n_q[g] <= !(in_range && (idx_x == ROW_ID));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_n_q   <= 1'b1;
      unpop_q   <= 1'b0;
      suspect_q <= 1'b0;
    end else begin
      cas_n_q   <= cas_n;
      unpop_q   <= normal && !in_range;
      suspect_q <= normal && dma_flag;
    end
  end
endmodule

// File: rtl/xram_row_decoder.sv
module xram_row_decoder #(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_BIT = 0,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS),
  localparam int unsigned SEL_W   = IDX_W - 1,
  localparam int unsigned CFG_W   = $clog2(IDX_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    host_row_sel,
  input  logic                host_ras_n,
  input  logic                host_cas_n,
  input  logic [DATA_W-1:0]   host_data,
  input  logic                cyc_start,
  input  logic                dma_cyc,
  input  logic [CFG_W-1:0]    cfg_rows,
  input  logic                cfg_big_rows,
  output logic [NUM_ROWS-1:0] row_ras_n,
  output logic                card_cas_n,
  output logic                row_size_big,
  output logic                unpop_access,
  output logic                dma_suspect
);
  logic             bank_w;
  logic             refresh_w;
  logic             eight_mode;
  logic [IDX_W-1:0] idx_w;
  logic [IDX_W:0]   count_w;

  assign eight_mode = (cfg_rows == CFG_W'(IDX_W));
  assign count_w    = (IDX_W + 1)'(1) << cfg_rows;
  assign idx_w      = {eight_mode & bank_w, host_row_sel};

  xrd_bank_latch #(.DATA_W(DATA_W), .BANK_BIT(BANK_BIT)) u_bank (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .dma_cyc(dma_cyc),
    .data(host_data), .bank_eff(bank_w)
  );

  xrd_cbr_detect u_cbr (
    .clk(clk), .rst(rst), .ras_n(host_ras_n), .cas_n(host_cas_n),
    .refresh(refresh_w)
  );

  xrd_row_drive #(.NUM_ROWS(NUM_ROWS)) u_drive (
    .clk(clk), .rst(rst), .ras_n(host_ras_n), .cas_n(host_cas_n),
    .refresh(refresh_w), .dma_flag(eight_mode && dma_cyc),
    .idx(idx_w), .count(count_w),
    .ras_n_q(row_ras_n), .cas_n_q(card_cas_n),
    .unpop_q(unpop_access), .suspect_q(dma_suspect)
  );

  always_ff @(posedge clk) begin
    if (rst) row_size_big <= 1'b0;
    else     row_size_big <= cfg_big_rows;
  end
endmodule

// File: rtl/xrd_checker.sv
module xrd_checker #(
  parameter int unsigned NUM_ROWS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          host_row_sel,
  input logic                host_ras_n,
  input logic                host_cas_n,
  input logic                dma_cyc,
  input logic [1:0]          cfg_rows,
  input logic                cfg_big_rows,
  input logic                refresh_w,
  input logic [NUM_ROWS-1:0] row_ras_n,
  input logic                card_cas_n,
  input logic                row_size_big,
  input logic                unpop_access,
  input logic                dma_suspect
);
  a_r1_size_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> row_size_big == $past(cfg_big_rows));

  a_r2_small_select: assert property (@(posedge clk) disable iff (rst)
    (cfg_rows != 2'd3 && !host_ras_n && !refresh_w &&
     ({2'b00, host_row_sel} < (4'd1 << cfg_rows)))
    |=> !row_ras_n[$past(host_row_sel)]);

  a_r6_unpop_quiet: assert property (@(posedge clk) disable iff (rst)
    unpop_access |-> &row_ras_n);

  a_r7_suspect_origin: assert property (@(posedge clk) disable iff (rst)
    dma_suspect |-> ($past(cfg_rows) == 2'd3 && $past(dma_cyc)));

  a_r8_refresh_row0: assert property (@(posedge clk) disable iff (rst)
    refresh_w |=> (!row_ras_n[0] && !unpop_access));

  a_r9_single_row: assert property (@(posedge clk) disable iff (rst)
    !$past(refresh_w) |-> $onehot0(~row_ras_n));

  a_r9_cas_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> card_cas_n == $past(host_cas_n));
endmodule

bind xram_row_decoder xrd_checker #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk(clk), .rst(rst), .host_row_sel(host_row_sel), .host_ras_n(host_ras_n),
  .host_cas_n(host_cas_n), .dma_cyc(dma_cyc), .cfg_rows(cfg_rows),
  .cfg_big_rows(cfg_big_rows), .refresh_w(refresh_w), .row_ras_n(row_ras_n),
  .card_cas_n(card_cas_n), .row_size_big(row_size_big),
  .unpop_access(unpop_access), .dma_suspect(dma_suspect)
);

// File: tb/xram_row_decoder_tb.sv
module xram_row_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] host_row_sel = 2'd0;
  logic       host_ras_n = 1'b1;
  logic       host_cas_n = 1'b1;
  logic [7:0] host_data = 8'h00;
  logic       cyc_start = 1'b0;
  logic       dma_cyc = 1'b0;
  logic [1:0] cfg_rows = 2'd0;
  logic       cfg_big_rows = 1'b0;
  logic [7:0] row_ras_n;
  logic       card_cas_n, row_size_big, unpop_access, dma_suspect;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xram_row_decoder dut_i (
    .clk(clk), .rst(rst), .host_row_sel(host_row_sel), .host_ras_n(host_ras_n),
    .host_cas_n(host_cas_n), .host_data(host_data), .cyc_start(cyc_start),
    .dma_cyc(dma_cyc), .cfg_rows(cfg_rows), .cfg_big_rows(cfg_big_rows),
    .row_ras_n(row_ras_n), .card_cas_n(card_cas_n), .row_size_big(row_size_big),
    .unpop_access(unpop_access), .dma_suspect(dma_suspect)
  );

  int    checks = 0;
  int    errors = 0;
  string tag_ovr = "";

  // behavioural reference state
  int       m_bank = 0, m_arm = 0, m_csp = 0;
  int       e_ras = 255, e_cas = 1, e_big = 0, e_unp = 0, e_sus = 0;
  string    e_tag = "R10";

  always @(posedge clk) begin
    int b, rf, cnt, idx, normal;
    if (rst) begin
      m_bank = 0; m_arm = 0; m_csp = 0;
      e_ras = 255; e_cas = 1; e_big = 0; e_unp = 0; e_sus = 0; e_tag = "R10";
    end else begin
      b = (cyc_start && m_csp == 0 && !dma_cyc) ? int'(host_data[0]) : m_bank;
      m_bank = b;
      m_csp = int'(cyc_start);
      rf = (m_arm == 1 && !host_ras_n) ? 1 : 0;
      if (host_cas_n) m_arm = 0;
      else if (host_ras_n) m_arm = 1;
      cnt = 1 << cfg_rows;
      idx = (cfg_rows == 2'd3) ? b * 4 + int'(host_row_sel) : int'(host_row_sel);
      normal = (!host_ras_n && rf == 0) ? 1 : 0;
      e_cas = int'(host_cas_n);
      e_big = int'(cfg_big_rows);
      e_unp = (normal == 1 && idx >= cnt) ? 1 : 0;
      e_sus = (normal == 1 && cfg_rows == 2'd3 && dma_cyc) ? 1 : 0;
      if (host_ras_n) e_ras = 255;
      else if (rf == 1) e_ras = 255 & ~((1 << cnt) - 1);
      else if (idx < cnt) e_ras = 255 & ~(1 << idx);
      else e_ras = 255;
      if (rf == 1) e_tag = "R8";
      else if (e_unp == 1) e_tag = "R6";
      else if (cfg_rows == 2'd3) e_tag = "R4";
      else e_tag = "R2";
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    string t;
    @(posedge clk);
    @(negedge clk);
    t = (tag_ovr != "") ? tag_ovr : e_tag;
    check(t, int'(row_ras_n), e_ras);
    check(rst ? "R10" : "R9", int'(card_cas_n), e_cas);
    check(rst ? "R10" : "R1", int'(row_size_big), e_big);
    check(rst ? "R10" : "R6", int'(unpop_access), e_unp);
    check(rst ? "R10" : "R7", int'(dma_suspect), e_sus);
  endtask

  task automatic access(input logic [1:0] sel, input logic dbit,
                        input logic cs, input logic dma);
    host_row_sel = sel; host_data = {7'd0, dbit}; cyc_start = cs; dma_cyc = dma;
    tick();
    cyc_start = 1'b0; host_ras_n = 1'b0;
    tick();
    host_cas_n = 1'b0;
    tick();
    host_ras_n = 1'b1; host_cas_n = 1'b1;
    tick();
    dma_cyc = 1'b0;
  endtask

  task automatic refresh_cycle();
    host_cas_n = 1'b0;
    tick();
    host_ras_n = 1'b0;
    tick();
    tick();
    host_ras_n = 1'b1; host_cas_n = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R10: reset state
    tag_ovr = "R10";
    tick(); tick();
    check("R10", int'(row_ras_n), 255);
    rst = 1'b0;
    tick();
    tag_ovr = "";

    // R2 / R6: small configurations, every select value
    for (int c = 0; c < 3; c++) begin
      cfg_rows = c[1:0];
      for (int s = 0; s < 4; s++) access(s[1:0], 1'b0, 1'b0, 1'b0);
    end

    // R5: bank byte ignored with four rows
    cfg_rows = 2'd2;
    tag_ovr = "R5";
    access(2'd2, 1'b1, 1'b1, 1'b0);
    access(2'd1, 1'b1, 1'b1, 1'b0);
    tag_ovr = "";

    // R3 / R4: eight rows, bank bit captured at cycle start
    cfg_rows = 2'd3;
    tag_ovr = "R3";
    access(2'd1, 1'b1, 1'b1, 1'b0);
    access(2'd3, 1'b0, 1'b0, 1'b0);   // held bit still 1
    access(2'd2, 1'b0, 1'b1, 1'b0);
    tag_ovr = "R4";
    for (int s = 0; s < 4; s++) access(s[1:0], 1'b1, 1'b1, 1'b0);

    // R7: DMA keeps the held bit and flags
    tag_ovr = "R7";
    access(2'd0, 1'b0, 1'b1, 1'b1);
    access(2'd2, 1'b0, 1'b0, 1'b0);
    cfg_rows = 2'd2;
    access(2'd3, 1'b1, 1'b1, 1'b1);
    tag_ovr = "";

    // R8: refresh in several configurations
    for (int c = 0; c < 4; c++) begin
      cfg_rows = c[1:0];
      refresh_cycle();
    end

    // R1: row-size strap
    cfg_big_rows = 1'b1;
    tick(); tick();
    check("R1", int'(row_size_big), 1);
    cfg_big_rows = 1'b0;
    tick();
    check("R1", int'(row_size_big), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule